// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is one compare channel. It holds a 16-bit compare value and checks it on every clock against the count of one of two free-running timers. The timers live elsewhere and arrive here as inputs that are synchronous to the module clock. A select bit picks the timer. When the selected count becomes equal to the compare value, the channel applies an action chosen by a 4-bit mode field to a private output latch. The action is set high, drive low, toggle or leave alone. On that same match the channel also sets an interrupt flag.

Software reaches the channel through a simple write port with four word addresses: compare value, mode, configuration and flag. The latch goes to the pin only while the tristate bit is clear. The interrupt request is the flag qualified by an enable bit. Each output reacts on the clock edge that ends the cycle in which the match is seen.

A small state machine inside the block tracks the match. It has three states:
- `ST_OFF`: the mode is disabled.
- `ST_WAIT`: the counts differ, so the channel is armed.
- `ST_HELD`: the counts are equal and the channel has already acted.

It moves between these states on five transitions:
- OFF→WAIT: the mode becomes valid while the counts differ.
- OFF→HELD: the mode becomes valid while the counts are equal. This transition does not fire.
- WAIT→HELD: the counts become equal. This transition fires.
- HELD→WAIT: the count leaves the compare value.
- any→OFF: the mode becomes invalid.

Top module: `ocu_top`

## Requirements
- R1: The compare value is written at address 0. It is compared each cycle against timer A when the configuration bit 0 at address 2 is 0, and against timer B when that bit is 1. The timer that is not selected has no effect.
- R2: Mode 4'b1000, written to address 1 bits [3:0], drives the latch high on a match.
- R3: Mode 4'b1001 drives the latch low on a match.
- R4: Mode 4'b0010 inverts the latch on a match.
- R5: Mode 4'b1010 sets the flag on a match and leaves the latch unchanged.
- R6: Any other nonzero mode disables compare. A match then sets no flag and leaves the latch unchanged.
- R7: A write of zero to the mode field forces the latch low on the next clock edge.
- R8: Only the first cycle of equality fires. A count that holds at the compare value does not fire again until it has left that value and come back. Enabling a valid mode while the counts are already equal does not fire.
- R9: A match sets the flag (port `cmp_flag`). A write to address 3 loads bit 0 into the flag, so writing 0 clears it. A match in the same cycle wins over that write.
- R10: `irq` is high exactly when the flag is set and the enable bit (address 2 bit 2) is 1.
- R11: When the tristate bit (address 2 bit 1) is 1, `pin_oe` and `pin_val` are 0 and the latch keeps its value. When the bit is 0, `pin_oe` is 1 and `pin_val` follows the latch.
- R12: After reset, the compare value, mode, select, enable, latch and flag are all 0, and the tristate bit is 1.
- R13: Outputs change on the clock edge that ends the cycle in which the match or the write is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 16 | Register write data |
| timer_a | input | 16 | Count of timebase A |
| timer_b | input | 16 | Count of timebase B |
| pin_val | output | 1 | Latch value presented to the pin, 0 while tristated |
| pin_oe | output | 1 | Pin output enable, the inverse of the tristate bit |
| cmp_flag | output | 1 | Compare interrupt flag |
| irq | output | 1 | Interrupt request, the flag qualified by the enable bit |

## Verification
The bound checker watches every cycle for the following:
- The flag rises after each fire.
- A fire is never followed by a second fire in the next cycle.
- Each mode drives the latch the way it should.
- A zero mode write clears the latch.
- A disabled mode never fires.
- The tristate bit silences the pin.

Some behaviour can only be shown by the bench's scenarios:
- The non-selected timer is ignored.
- Re-arming happens only after the count leaves the compare value.
- Enabling a mode while the counts are already equal stays quiet.
- The flag write and a match in the same cycle resolve in favour of the match.
- The latch survives a period with the pin tristated.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    // register word addresses
    localparam logic [1:0] ADDR_CMP  = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_CFG  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    // configuration bit positions
    localparam int CFG_TSEL = 0;
    localparam int CFG_HIZ  = 1;
    localparam int CFG_IE   = 2;

    // mode field encodings
    localparam logic [3:0] MD_OFF    = 4'b0000;
    localparam logic [3:0] MD_TOGGLE = 4'b0010;
    localparam logic [3:0] MD_SET    = 4'b1000;
    localparam logic [3:0] MD_CLEAR  = 4'b1001;
    localparam logic [3:0] MD_SWI    = 4'b1010;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_HELD = 2'd2
    } match_st_t;

    function automatic logic mode_active(input logic [3:0] m);
        return (m == MD_TOGGLE) || (m == MD_SET) ||
               (m == MD_CLEAR)  || (m == MD_SWI);
    endfunction

endpackage

// File: rtl/ocu_regs.sv
module ocu_regs
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cmp_val,
    output logic [3:0]       mode,
    output logic             tsel,
    output logic             hiz,
    output logic             ie,
    output logic             mode_zero_wr,
    output logic             flag_wr,
    output logic             flag_wr_val
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val <= '0;
            mode    <= MD_OFF;
            tsel    <= 1'b0;
            hiz     <= 1'b1;
            ie      <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CMP:  cmp_val <= wr_data;
                ADDR_MODE: mode    <= wr_data[3:0];
                ADDR_CFG: begin
                    tsel <= wr_data[CFG_TSEL];
                    hiz  <= wr_data[CFG_HIZ];
                    ie   <= wr_data[CFG_IE];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mode_zero_wr = wr_en && (wr_addr == ADDR_MODE) && (wr_data[3:0] == MD_OFF);
        flag_wr      = wr_en && (wr_addr == ADDR_FLAG);
        flag_wr_val  = wr_data[0];
    end

endmodule

// File: rtl/ocu_match_fsm.sv
module ocu_match_fsm
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] timer_a,
    input  logic [CNT_W-1:0] timer_b,
    input  logic             tsel,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [3:0]       mode,
    output logic             eq,
    output logic             fire
);

    match_st_t st_q, st_d;
    logic [CNT_W-1:0] count_sel;
    logic             active;

    always_comb begin
        count_sel = tsel ? timer_b : timer_a;
        eq        = (count_sel == cmp_val);
        active    = mode_active(mode);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:  st_d = eq ? ST_HELD : ST_WAIT;
                ST_WAIT: st_d = eq ? ST_HELD : ST_WAIT;
                ST_HELD: st_d = eq ? ST_HELD : ST_WAIT;
                default: st_d = ST_OFF;
            endcase
        end
    end

    // outputs: fire only on the WAIT->HELD transition
    always_comb begin
        fire = 1'b0;
        unique case (st_q)
            ST_WAIT: fire = active && eq;
            ST_OFF,
            ST_HELD: fire = 1'b0;
            default: fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/ocu_out.sv
module ocu_out
    import ocu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [3:0] mode,
    input  logic       mode_zero_wr,
    input  logic       flag_wr,
    input  logic       flag_wr_val,
    input  logic       hiz,
    input  logic       ie,
    output logic       latch,
    output logic       flag,
    output logic       pin_val,
    output logic       pin_oe,
    output logic       irq
);

    logic latch_d, flag_d;

    always_comb begin
        latch_d = latch;
        if (mode_zero_wr) begin
            latch_d = 1'b0;
        end else if (fire) begin
            unique case (mode)
                MD_SET:    latch_d = 1'b1;
                MD_CLEAR:  latch_d = 1'b0;
                MD_TOGGLE: latch_d = ~latch;
                default:   latch_d = latch;
            endcase
        end
        flag_d = flag;
        if (fire)         flag_d = 1'b1;
        else if (flag_wr) flag_d = flag_wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= 1'b0;
            flag  <= 1'b0;
        end else begin
            latch <= latch_d;
            flag  <= flag_d;
        end
    end

    always_comb begin
        pin_oe  = ~hiz;
        pin_val = latch & ~hiz;
        irq     = flag & ie;
    end

endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] timer_a,
    input  logic [CNT_W-1:0] timer_b,
    output logic             pin_val,
    output logic             pin_oe,
    output logic             cmp_flag,
    output logic             irq
);

    logic [CNT_W-1:0] cmp_val;
    logic [3:0]       mode;
    logic             tsel, hiz, ie;
    logic             mode_zero_wr, flag_wr, flag_wr_val;
    logic             eq, fire, latch;

    ocu_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cmp_val      (cmp_val),
        .mode         (mode),
        .tsel         (tsel),
        .hiz          (hiz),
        .ie           (ie),
        .mode_zero_wr (mode_zero_wr),
        .flag_wr      (flag_wr),
        .flag_wr_val  (flag_wr_val)
    );

    ocu_match_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .timer_a (timer_a),
        .timer_b (timer_b),
        .tsel    (tsel),
        .cmp_val (cmp_val),
        .mode    (mode),
        .eq      (eq),
        .fire    (fire)
    );

    ocu_out u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .mode         (mode),
        .mode_zero_wr (mode_zero_wr),
        .flag_wr      (flag_wr),
        .flag_wr_val  (flag_wr_val),
        .hiz          (hiz),
        .ie           (ie),
        .latch        (latch),
        .flag         (cmp_flag),
        .pin_val      (pin_val),
        .pin_oe       (pin_oe),
        .irq          (irq)
    );

endmodule

// File: rtl/ocu_checker.sv
module ocu_checker
    import ocu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       fire,
    input logic [3:0] mode,
    input logic       mode_zero_wr,
    input logic       latch,
    input logic       cmp_flag,
    input logic       ie,
    input logic       hiz,
    input logic       pin_val,
    input logic       pin_oe,
    input logic       irq
);

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cmp_flag); // R9

    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R8

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == MD_SET && !mode_zero_wr) |=> latch); // R2

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == MD_CLEAR && !mode_zero_wr) |=> !latch); // R3

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == MD_TOGGLE && !mode_zero_wr) |=> (latch != $past(latch))); // R4

    AST_SWI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == MD_SWI && !mode_zero_wr) |=> $stable(latch)); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_active(mode) |-> !fire); // R6

    AST_ZERO_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mode_zero_wr |=> !latch); // R7

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq); // R10

    AST_HIZ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        hiz |-> (!pin_oe && !pin_val)); // R11

endmodule

bind ocu_top ocu_checker u_ocu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .mode         (mode),
    .mode_zero_wr (mode_zero_wr),
    .latch        (latch),
    .cmp_flag     (cmp_flag),
    .ie           (ie),
    .hiz          (hiz),
    .pin_val      (pin_val),
    .pin_oe       (pin_oe),
    .irq          (irq)
);

// File: tb/test_ocu_top.sv
module test_ocu_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic  val;
        logic  oe;
        logic  flg;
        logic  irq;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] timer_a = '0;
    logic [15:0] timer_b = '0;
    logic        pin_val, pin_oe, cmp_flag, irq;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ocu_top i_ocu_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .timer_a  (timer_a),
        .timer_b  (timer_b),
        .pin_val  (pin_val),
        .pin_oe   (pin_oe),
        .cmp_flag (cmp_flag),
        .irq      (irq)
    );

    // one clock cycle with the given inputs; returns just after the edge
    task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d,
                       input logic [15:0] ta, input logic [15:0] tb);
        @(negedge clk);
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        timer_a = ta;
        timer_b = tb;
        @(posedge clk);
        #1;
    endtask

    // driver side of the scoreboard: expected state after the last edge
    task automatic expect_out(input logic v, input logic oe, input logic f,
                              input logic i, input string tag);
        exp_t e;
        e.val = v; e.oe = oe; e.flg = f; e.irq = i; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_tests++;
                if (pin_val !== e.val || pin_oe !== e.oe ||
                    cmp_flag !== e.flg || irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: got val=%b oe=%b flag=%b irq=%b, expected val=%b oe=%b flag=%b irq=%b",
                             e.tag, pin_val, pin_oe, cmp_flag, irq, e.val, e.oe, e.flg, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h0);
        expect_out(0, 0, 0, 0, "R12 reset state");
        cyc(1, 2'd2, 16'h0004, 16'h0, 16'h0);            // oe on, ie on, timer A
        expect_out(0, 1, 0, 0, "R11 pin enabled, latch low");
        cyc(1, 2'd0, 16'h1234, 16'h0, 16'h0);
        cyc(1, 2'd1, 16'h0008, 16'h0, 16'h0);            // set mode
        cyc(0, 2'd0, 16'h0, 16'h1233, 16'h0);
        expect_out(0, 1, 0, 0, "R1 no action one below compare");
        cyc(0, 2'd0, 16'h0, 16'h1234, 16'h0);
        expect_out(1, 1, 1, 1, "R2 set on match, R13 next edge");
        cyc(0, 2'd0, 16'h0, 16'h1234, 16'h0);
        expect_out(1, 1, 1, 1, "R8 held count");
        cyc(1, 2'd3, 16'h0000, 16'h1234, 16'h0);
        expect_out(1, 1, 0, 0, "R9 flag cleared by write");
        cyc(0, 2'd0, 16'h0, 16'h1234, 16'h0);
        expect_out(1, 1, 0, 0, "R8 no repeat while held");
        cyc(0, 2'd0, 16'h0, 16'h1235, 16'h0);
        cyc(0, 2'd0, 16'h0, 16'h1234, 16'h0);
        expect_out(1, 1, 1, 1, "R8 rearmed after leaving");
        cyc(1, 2'd3, 16'h0000, 16'h1000, 16'h0);
        cyc(1, 2'd1, 16'h0009, 16'h1000, 16'h0);         // clear mode
        expect_out(1, 1, 0, 0, "R3 before match");
        cyc(0, 2'd0, 16'h0, 16'h1234, 16'h0);
        expect_out(0, 1, 1, 1, "R3 drive low on match");
        cyc(1, 2'd3, 16'h0000, 16'h0, 16'h0);
        cyc(1, 2'd2, 16'h0005, 16'h0, 16'h0);            // timer B
        cyc(1, 2'd1, 16'h0002, 16'h1234, 16'h0);         // toggle mode
        cyc(0, 2'd0, 16'h0, 16'h1234, 16'h0);
        expect_out(0, 1, 0, 0, "R1 unselected timer ignored");
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h1234);
        expect_out(1, 1, 1, 1, "R1 R4 timer B toggles high");
        cyc(1, 2'd3, 16'h0000, 16'h0, 16'h2000);
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h1234);
        expect_out(0, 1, 1, 1, "R4 toggles low");
        cyc(1, 2'd3, 16'h0000, 16'h0, 16'h0);
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h1234);
        expect_out(1, 1, 1, 1, "R4 toggles high again");
        cyc(1, 2'd1, 16'h000A, 16'h0, 16'h0);            // interrupt-only mode
        cyc(1, 2'd3, 16'h0000, 16'h0, 16'h0);
        expect_out(1, 1, 0, 0, "R9 flag cleared");
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h1234);
        expect_out(1, 1, 1, 1, "R5 flag only, latch kept");
        cyc(1, 2'd3, 16'h0000, 16'h0, 16'h0);
        cyc(1, 2'd3, 16'h0000, 16'h0, 16'h1234);
        expect_out(1, 1, 1, 1, "R9 match wins over clear");
        cyc(1, 2'd2, 16'h0001, 16'h0, 16'h1234);         // ie off
        expect_out(1, 1, 1, 0, "R10 irq masked");
        cyc(1, 2'd2, 16'h0003, 16'h0, 16'h0);            // tristate
        expect_out(0, 0, 1, 0, "R11 tristated pin");
        cyc(1, 2'd2, 16'h0005, 16'h0, 16'h0);
        expect_out(1, 1, 1, 1, "R11 latch kept through tristate, R10 irq");
        cyc(1, 2'd3, 16'h0000, 16'h0, 16'h0);
        cyc(1, 2'd1, 16'h0005, 16'h0, 16'h0);            // disabled mode
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h1234);
        expect_out(1, 1, 0, 0, "R6 disabled mode ignores match");
        cyc(1, 2'd1, 16'h0000, 16'h0, 16'h1234);
        expect_out(0, 1, 0, 0, "R7 zero mode forces latch low");
        cyc(1, 2'd1, 16'h0008, 16'h0, 16'h1234);
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h1234);
        expect_out(0, 1, 0, 0, "R8 enable while equal does not fire");
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h0);
        cyc(0, 2'd0, 16'h0, 16'h0, 16'h1234);
        expect_out(1, 1, 1, 1, "R8 fires after leaving");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule